// File: doc/BRIEF.md
# RAM Download Frame Assembler

This block turns one "load this payload into target RAM" request into a single long serial-bus message and hands it, one byte per accepted handshake, to a transmit FIFO. A controller presents the target load address, the payload length and a flag that says whether the target should jump to the code once it lands. When it pulses `start`, the block latches those values and streams the fixed header, a mode byte, a control byte, the length and the address. It then passes the payload through from a ready/valid source, appends a 16-bit additive block checksum and closes with a CRC-8 over the whole frame.

The receiving bus controller corrupts a frame if its transmit FIFO runs dry part way through. For that reason the block only accepts a request when the upstream buffer already reports at least the full payload length. After that, the only thing that can pause the stream is a full FIFO (`out_ready` low). That pause is back-pressure, not an underrun.

The sequencer moves through the states IDLE, HEAD (ten fixed and parameter bytes), BODY (payload), SUMH and SUML (checksum bytes) and CRC (final byte). The transitions are:
- `start` with enough buffered data takes IDLE to HEAD.
- The tenth header byte moves HEAD to BODY, or straight to SUMH when the length is zero.
- The last payload byte moves BODY to SUMH.
- Each accepted byte moves SUMH to SUML, SUML to CRC, and CRC back to IDLE.

Top module: `dl_frame_asm`

## Requirements
- R1: After reset the block is idle: `busy`, `out_valid` and `in_ready` are all 0.
- R2: The first four frame bytes are 6D, 10, F0, 36 in that order.
- R3: The fifth byte is 80 when `exec_i` was 1 at the accepted start, else 00.
- R4: Bytes 6–7 carry the payload length and bytes 8–10 the 24-bit load address, each most significant byte first.
- R5: The payload bytes follow in arrival order. `in_ready` is high only while payload bytes are due, and the frame holds exactly length + 13 bytes.
- R6: After the payload come two bytes holding the sum modulo 65536 of every byte from the control byte through the last payload byte, high byte first.
- R7: The final byte is a CRC-8 over all earlier frame bytes: polynomial 0x1D, MSB first, register preset to FF, result inverted.
- R8: `out_last` is 1 on the final (CRC) byte only, and the block is idle in the cycle after that byte is accepted.
- R9: A `start` is refused (no frame, `busy` stays 0) when `src_level` is below `len_i`. A `start` while busy is ignored and changes neither the current frame nor what follows it.
- R10: A length of zero gives a 13-byte frame with no payload bytes and checksum 0x0000 + control byte + address bytes.
- R11: While `out_valid` is 1 and `out_ready` is 0, the presented byte stays valid and unchanged until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a frame |
| exec_i | input | 1 | 1: download and execute, 0: download only |
| addr_i | input | 24 | Target load address |
| len_i | input | 16 | Payload length in bytes |
| src_level | input | 16 | Bytes already buffered upstream |
| in_valid | input | 1 | Payload byte valid |
| in_data | input | 8 | Payload byte |
| in_ready | output | 1 | Payload byte taken this cycle |
| out_valid | output | 1 | Frame byte presented |
| out_data | output | 8 | Frame byte |
| out_last | output | 1 | Presented byte ends the frame |
| out_ready | input | 1 | FIFO can take a byte |
| busy | output | 1 | A frame is in progress |

## Verification
A stale or misaligned byte counter shows at the ports as a shifted field, or as a frame that is one byte long or short. Either appears within the same frame as a byte mismatch or a misplaced `out_last`. A checksum or CRC register that is not cleared, or that skips or double-counts a byte, stays hidden through the whole payload. It only surfaces at the last three bytes of the frame, so every frame is compared byte by byte through its end, with and without back-pressure. A refused or ignored `start` that slips through shows one cycle later as `busy` or as a spurious extra frame.

// File: rtl/dl_frame_pkg.sv
package dl_frame_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_HEAD,
        S_BODY,
        S_SUMH,
        S_SUML,
        S_CRC
    } dl_state_e;

    localparam int HEAD_BYTES = 10;
    localparam int SUM_FROM   = 4;
    localparam logic [7:0] CRC_POLY  = 8'h1D;
    localparam logic [7:0] CRC_SEED  = 8'hFF;
    localparam logic [7:0] CTL_EXEC  = 8'h80;
    localparam logic [7:0] CTL_LOAD  = 8'h00;

    function automatic logic [7:0] crc8_step(input logic [7:0] crc, input logic [7:0] d);
        logic [7:0] c;
        c = crc ^ d;
        for (int b = 0; b < 8; b++) begin
            c = c[7] ? ((c << 1) ^ CRC_POLY) : (c << 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/dlf_crc8.sv
module dlf_crc8
    import dl_frame_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       en,
    input  logic [7:0] byte_i,
    output logic [7:0] crc_o
);
    logic [7:0] acc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= CRC_SEED;
        end else if (clr) begin
            acc_q <= CRC_SEED;
        end else if (en) begin
            acc_q <= crc8_step(acc_q, byte_i);
        end
    end

    assign crc_o = ~acc_q;
endmodule

// File: rtl/dlf_sum16.sv
module dlf_sum16 #(
    parameter int SUM_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [7:0]       byte_i,
    output logic [SUM_W-1:0] sum_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_o <= '0;
        end else if (clr) begin
            sum_o <= '0;
        end else if (en) begin
            sum_o <= sum_o + SUM_W'(byte_i);
        end
    end
endmodule

// File: rtl/dlf_seq.sv
module dlf_seq
    import dl_frame_pkg::*;
#(
    parameter int LEN_W  = 16,
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              exec_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [LEN_W-1:0]  src_level,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [7:0]        out_data,
    output logic              out_last,
    input  logic              out_ready,
    output logic              busy,
    input  logic [15:0]       sum_i,
    input  logic [7:0]        crc_i,
    output logic              acc_clr,
    output logic              sum_en,
    output logic              crc_en
);
    localparam logic [LEN_W-1:0] HEAD_LAST = LEN_W'(HEAD_BYTES - 1);
    localparam logic [LEN_W-1:0] SUM_IDX   = LEN_W'(SUM_FROM);

    dl_state_e         state_q, state_d;
    logic [LEN_W-1:0]  idx_q;
    logic [LEN_W-1:0]  len_q;
    logic [ADDR_W-1:0] addr_q;
    logic              exec_q;
    logic              go, fire;

    assign go   = (state_q == S_IDLE) && start && (src_level >= len_i);
    assign fire = out_valid && out_ready;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (go) state_d = S_HEAD;
            S_HEAD: if (fire && idx_q == HEAD_LAST)
                        state_d = (len_q == '0) ? S_SUMH : S_BODY;
            S_BODY: if (fire && idx_q == len_q - 1'b1) state_d = S_SUMH;
            S_SUMH: if (fire) state_d = S_SUML;
            S_SUML: if (fire) state_d = S_CRC;
            S_CRC:  if (fire) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q) idx_q <= '0;
            else if (fire)          idx_q <= idx_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q  <= '0;
            addr_q <= '0;
            exec_q <= 1'b0;
        end else if (go) begin
            len_q  <= len_i;
            addr_q <= addr_i;
            exec_q <= exec_i;
        end
    end

    function automatic logic [7:0] head_byte(input logic [3:0] i);
        case (i)
            4'd0:    return 8'h6D;
            4'd1:    return 8'h10;
            4'd2:    return 8'hF0;
            4'd3:    return 8'h36;
            4'd4:    return exec_q ? CTL_EXEC : CTL_LOAD;
            4'd5:    return len_q[15:8];
            4'd6:    return len_q[7:0];
            4'd7:    return addr_q[23:16];
            4'd8:    return addr_q[15:8];
            default: return addr_q[7:0];
        endcase
    endfunction

    always_comb begin
        out_valid = (state_q != S_IDLE);
        busy      = out_valid;
        out_last  = (state_q == S_CRC);
        in_ready  = (state_q == S_BODY) && out_ready;
        acc_clr   = go;
        out_data  = 8'h00;
        unique case (state_q)
            S_IDLE: out_data = 8'h00;
            S_HEAD: out_data = head_byte(idx_q[3:0]);
            S_BODY: out_data = in_data;
            S_SUMH: out_data = sum_i[15:8];
            S_SUML: out_data = sum_i[7:0];
            S_CRC:  out_data = crc_i;
            default: out_data = 8'h00;
        endcase
        sum_en = fire && (((state_q == S_HEAD) && (idx_q >= SUM_IDX)) || (state_q == S_BODY));
        crc_en = fire && (state_q != S_CRC);
    end

    AST_NO_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_BODY && out_ready) |-> in_valid); // R5
    AST_REFUSE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && start && src_level < len_i) |=> (state_q == S_IDLE)); // R9
    AST_HOLD_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R11
    AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && out_last) |=> !busy); // R8
endmodule

// File: rtl/dl_frame_asm.sv
module dl_frame_asm
    import dl_frame_pkg::*;
#(
    parameter int LEN_W  = 16,
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              exec_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [LEN_W-1:0]  src_level,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [7:0]        out_data,
    output logic              out_last,
    input  logic              out_ready,
    output logic              busy
);
    logic [15:0] sum_w;
    logic [7:0]  crc_w;
    logic        clr_w, sum_en_w, crc_en_w;

    dlf_seq #(.LEN_W(LEN_W), .ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .exec_i(exec_i),
        .addr_i(addr_i), .len_i(len_i), .src_level(src_level),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
        .out_ready(out_ready), .busy(busy), .sum_i(sum_w), .crc_i(crc_w),
        .acc_clr(clr_w), .sum_en(sum_en_w), .crc_en(crc_en_w)
    );

    dlf_sum16 #(.SUM_W(16)) u_sum (
        .clk(clk), .rst_n(rst_n), .clr(clr_w), .en(sum_en_w),
        .byte_i(out_data), .sum_o(sum_w)
    );

    dlf_crc8 u_crc (
        .clk(clk), .rst_n(rst_n), .clr(clr_w), .en(crc_en_w),
        .byte_i(out_data), .crc_o(crc_w)
    );
endmodule

// File: tb/tb_dl_frame_asm.sv
module tb_dl_frame_asm;
    typedef struct packed {
        logic        ex;
        logic [23:0] addr;
        logic [15:0] len;
        logic [7:0]  seed;
        logic        bp;
        logic        poke;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 24'h001810, 16'h0070, 8'h03, 1'b0, 1'b0},
        '{1'b0, 24'h00A55A, 16'h0001, 8'h09, 1'b1, 1'b0},
        '{1'b1, 24'h123456, 16'h0000, 8'h00, 1'b1, 1'b0},
        '{1'b0, 24'hFFFFFF, 16'h0100, 8'h5A, 1'b1, 1'b1},
        '{1'b1, 24'h000300, 16'h0834, 8'hC7, 1'b1, 1'b0},
        '{1'b0, 24'h7E0001, 16'h0005, 8'hE1, 1'b0, 1'b1}
    };

    logic        clk = 0, rst_n = 0, start = 0, exec_i = 0;
    logic [23:0] addr_i = '0;
    logic [15:0] len_i = '0, src_level = '0;
    logic        in_valid = 0, out_ready = 0;
    logic [7:0]  in_data = '0;
    logic        in_ready, out_valid, out_last, busy;
    logic [7:0]  out_data;

    int n_chk = 0, n_bad = 0;
    logic [7:0] pay [4096];
    logic [7:0] expf [4200];

    always #4 clk = ~clk;

    dl_frame_asm dut (
        .clk(clk), .rst_n(rst_n), .start(start), .exec_i(exec_i),
        .addr_i(addr_i), .len_i(len_i), .src_level(src_level),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
        .out_ready(out_ready), .busy(busy)
    );

    function automatic logic [7:0] m_crc(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] r = c ^ d;
        for (int b = 0; b < 8; b++) r = r[7] ? ((r << 1) ^ 8'h1D) : (r << 1);
        return r;
    endfunction

    function automatic string field(input int k, input int n);
        if (k < 4) return "R2";
        if (k == 4) return "R3";
        if (k < 10) return "R4";
        if (k < n - 3) return "R5";
        if (k < n - 1) return "R6";
        return "R7";
    endfunction

    task automatic chk(input string req, input logic ok, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic build(input vec_t v, output int n);
        logic [15:0] s = 16'h0;
        logic [7:0]  c = 8'hFF;
        n = int'(v.len) + 13;
        for (int i = 0; i < int'(v.len); i++) pay[i] = 8'((v.seed * 7) + i * 13 + (i >> 3));
        expf[0] = 8'h6D; expf[1] = 8'h10; expf[2] = 8'hF0; expf[3] = 8'h36;
        expf[4] = v.ex ? 8'h80 : 8'h00;
        expf[5] = v.len[15:8]; expf[6] = v.len[7:0];
        expf[7] = v.addr[23:16]; expf[8] = v.addr[15:8]; expf[9] = v.addr[7:0];
        for (int i = 0; i < int'(v.len); i++) expf[10 + i] = pay[i];
        for (int i = 4; i < n - 3; i++) s = s + 16'(expf[i]);
        expf[n-3] = s[15:8]; expf[n-2] = s[7:0];
        for (int i = 0; i < n - 1; i++) c = m_crc(c, expf[i]);
        expf[n-1] = ~c;
    endtask

    task automatic run_vec(input vec_t v);
        int n, k, pos, cyc;
        logic held;
        logic [7:0] hd;
        build(v, n);
        @(negedge clk);
        start = 1; exec_i = v.ex; addr_i = v.addr; len_i = v.len; src_level = v.len;
        in_valid = 0; out_ready = 0;
        @(negedge clk);
        start = 0;
        k = 0; pos = 0; cyc = 0; held = 0; hd = '0;
        while (k < n && cyc < 20000) begin
            out_ready = v.bp ? ((cyc % 3) != 2) : 1'b1;
            if (v.poke && cyc == 3) begin
                start = 1; exec_i = ~v.ex; len_i = 16'd7; addr_i = 24'h0; src_level = 16'hFFFF;
            end else begin
                start = 0;
            end
            in_valid = (pos < int'(v.len));
            in_data  = pay[pos];
            #1;
            if (held) chk("R11", out_valid && out_data == hd, out_data, hd);
            held = 0;
            if (out_valid && !out_ready) begin held = 1; hd = out_data; end
            if (out_valid && out_ready) begin
                chk(field(k, n), out_data == expf[k], out_data, expf[k]);
                chk("R8", out_last == (k == n - 1), out_last, k == n - 1);
                k++;
            end
            if (in_ready && in_valid) pos++;
            cyc++;
            @(negedge clk);
        end
        start = 0; in_valid = 0;
        chk("R5 watchdog", cyc < 20000, cyc, 20000);
        #1;
        chk("R8/R9 idle after frame", !busy && !out_valid, busy, 0);
        chk(v.len == 0 ? "R10 length" : "R5 length", k == n && pos == int'(v.len), pos, v.len);
    endtask

    initial begin
        #(200000 * 8);
        n_bad++;
        $display("FAIL watchdog expired got 1 expected 0");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] c;
        // R7: CRC model against known short vectors
        c = 8'hFF; for (int i = 0; i < 4; i++) c = m_crc(c, 8'h00);
        chk("R7 model", ~c == 8'h59, ~c, 8'h59);
        c = 8'hFF; c = m_crc(c, 8'hF2); c = m_crc(c, 8'h01); c = m_crc(c, 8'h83);
        chk("R7 model", ~c == 8'h37, ~c, 8'h37);
        c = 8'hFF; for (int i = 0; i < 4; i++) c = m_crc(c, 8'hFF);
        chk("R7 model", ~c == 8'h74, ~c, 8'h74);

        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        chk("R1", !busy && !out_valid && !in_ready, {busy, out_valid, in_ready}, 0);

        for (int i = 0; i < NV; i++) run_vec(VEC[i]);

        // R9: refused start when upstream holds too few bytes
        @(negedge clk);
        start = 1; exec_i = 1; addr_i = 24'h1; len_i = 16'd10; src_level = 16'd9; out_ready = 1;
        @(negedge clk);
        start = 0;
        #1;
        chk("R9 refuse", !busy && !out_valid, busy, 0);
        @(negedge clk);
        #1;
        chk("R9 refuse hold", !busy && !out_valid && !in_ready, busy, 0);

        // R1: reset mid-frame returns to idle
        @(negedge clk);
        start = 1; len_i = 16'd20; src_level = 16'd20;
        @(negedge clk);
        start = 0;
        rst_n = 0;
        #1;
        chk("R1 reset", !busy && !out_valid && !in_ready, busy, 0);
        @(negedge clk);
        rst_n = 1;

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule